// File: doc/BRIEF.md
# Self-Synchronizing Payload Scrambler

This block whitens or restores a serial stream of cell payload, one bit per clock. It keeps a 43-deep history of scrambled bits, taken from the polynomial x^43+1. In scramble mode each payload bit leaves as the input bit XOR the oldest history bit, and that output bit is what enters the history. In descramble mode the received line bit enters the history, and the output is the received bit XOR the oldest history bit. Because the history holds only line bits, a descrambler locks onto a scrambler on its own: after 43 payload bits its history matches, whatever it held before.

A valid strobe marks the clocks that carry a bit, and a payload-enable input marks the bits to be scrambled. Header bits and other non-payload bits pass through unchanged and leave the history as it was. One register stage lies between input and output.

Top module: `cell_scrambler`

## Requirements
- R1: The history register has HIST_LEN stages (default 43). On an active bit (inValid=1 and payloadEn=1), the output is the input bit XOR the oldest stage.
- R2: With descramble=0 (scramble mode), an active bit writes the output bit into the first stage.
- R3: With descramble=1 (descramble mode), an active bit writes the received input bit into the first stage, and the output is the received bit XOR the oldest stage.
- R4: On an active bit, stage k+1 takes the old value of stage k. The history changes on no other clock.
- R5: A bit with inValid=1 and payloadEn=0 appears at the output unchanged, and the history does not move.
- R6: When inValid=0, outValid is 0 one clock later, outData keeps its value and the history does not move.
- R7: outValid equals inValid delayed by one clock, and outData belongs to the bit presented one clock earlier.
- R8: A synchronous reset (rst=1 at a rising clock edge) clears every history stage, outValid and outData to 0.
- R9: A descrambler whose history starts from any contents produces the original payload for every bit after the first 43 payload bits taken from a scrambler's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| descramble | input | 1 | 0 = scramble, 1 = descramble |
| inValid | input | 1 | The input bit is present this clock |
| payloadEn | input | 1 | The input bit is payload and is transformed |
| inData | input | 1 | Serial input bit |
| outValid | output | 1 | Registered valid, one clock after inValid |
| outData | output | 1 | Registered serial output bit |

## Verification
The bench builds two copies with the default HIST_LEN of 43: one fixed in scramble mode and one in descramble mode. A bench-side mux can feed the descrambler either from the scrambler's output or straight from the bench. Feeding it straight lets the bench load its history with random contents before it is linked to the scrambler. At the default depth, the self-synchronization window of 43 bits is within reach, and so is the oldest-stage tap that a run of more than 43 payload bits exercises. Mixing in non-payload bits and valid gaps shows whether the history really pauses.

// File: rtl/scr_pkg.sv
package scr_pkg;
  // control strobes handed from the control module to the datapath
  typedef struct packed {
    logic capture;   // a bit is present, update the output register
    logic shiftEn;   // payload bit: transform and advance the history
    logic feedRecv;  // history takes the received bit rather than the output bit
  } strobe_t;
endpackage

// File: rtl/scr_ctrl.sv
module scr_ctrl
  import scr_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    descramble,
  input  logic    inValid,
  input  logic    payloadEn,
  output strobe_t st,
  output logic    outValid
);
  always_comb begin
    st.capture  = inValid;
    st.shiftEn  = inValid && payloadEn;
    st.feedRecv = descramble;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  // R6
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
endmodule

// File: rtl/scr_datapath.sv
module scr_datapath
  import scr_pkg::*;
#(
  parameter int HIST_LEN = 43
) (
  input  logic    clk,
  input  logic    rst,
  input  strobe_t st,
  input  logic    inData,
  output logic    outData
);
  localparam int LAST = HIST_LEN - 1;

  logic [LAST:0] hist;
  logic          mixed;
  logic          feedBit;
  logic          nextOut;

  always_comb begin
    mixed   = inData ^ hist[LAST];
    nextOut = st.shiftEn ? mixed : inData;
    feedBit = st.feedRecv ? inData : mixed;
  end

  // first stage takes the feedback bit
  always_ff @(posedge clk) begin
    if (rst)             hist[0] <= 1'b0;
    else if (st.shiftEn) hist[0] <= feedBit;
  end

  // remaining stages form a plain delay line
  for (genvar g = 1; g <= LAST; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)             hist[g] <= 1'b0;
      else if (st.shiftEn) hist[g] <= hist[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             outData <= 1'b0;
    else if (st.capture) outData <= nextOut;
  end

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (hist == '0 && outData == 1'b0));
  // R4
  hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !st.shiftEn |=> $stable(hist));
  // R4
  hist_advance_chk: assert property (@(posedge clk) disable iff (rst)
    st.shiftEn |=> hist[LAST:1] == $past(hist[LAST-1:0]));
  // R2
  scr_feed_chk: assert property (@(posedge clk) disable iff (rst)
    (st.shiftEn && !st.feedRecv) |=> hist[0] == outData);
  // R3
  dsc_feed_chk: assert property (@(posedge clk) disable iff (rst)
    (st.shiftEn && st.feedRecv) |=> hist[0] == $past(inData));
  // R5
  pass_thru_chk: assert property (@(posedge clk) disable iff (rst)
    (st.capture && !st.shiftEn) |=> outData == $past(inData));
  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !st.capture |=> $stable(outData));
endmodule

// File: rtl/cell_scrambler.sv
module cell_scrambler
  import scr_pkg::*;
#(
  parameter int HIST_LEN = 43
) (
  input  logic clk,
  input  logic rst,
  input  logic descramble,
  input  logic inValid,
  input  logic payloadEn,
  input  logic inData,
  output logic outValid,
  output logic outData
);
  strobe_t st;

  scr_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .descramble (descramble),
    .inValid    (inValid),
    .payloadEn  (payloadEn),
    .st         (st),
    .outValid   (outValid)
  );

  scr_datapath #(.HIST_LEN(HIST_LEN)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .st      (st),
    .inData  (inData),
    .outData (outData)
  );
endmodule

// File: tb/tb_cell_scrambler.sv
module tb_cell_scrambler;
  localparam int PERIOD = 10;
  localparam int LEN = 43;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(PERIOD/2) clk = ~clk;

  // scrambler side
  logic sValid = 1'b0, sPe = 1'b0, sData = 1'b0;
  logic sOutValid, sOutData;
  // descrambler side (direct drive or linked to scrambler)
  logic linked = 1'b0;
  logic dValidDir = 1'b0, dPeDir = 1'b0, dDataDir = 1'b0;
  logic dValid, dPe, dData;
  logic dOutValid, dOutData;

  assign dValid = linked ? sOutValid : dValidDir;
  assign dPe    = linked ? sOutValid : dPeDir;
  assign dData  = linked ? sOutData  : dDataDir;

  cell_scrambler #(.HIST_LEN(LEN)) dut (
    .clk(clk), .rst(rst), .descramble(1'b0),
    .inValid(sValid), .payloadEn(sPe), .inData(sData),
    .outValid(sOutValid), .outData(sOutData));

  cell_scrambler #(.HIST_LEN(LEN)) dsc (
    .clk(clk), .rst(rst), .descramble(1'b1),
    .inValid(dValid), .payloadEn(dPe), .inData(dData),
    .outValid(dOutValid), .outData(dOutData));

  int checks = 0;
  int fails  = 0;
  logic [LEN-1:0] model;
  logic [255:0] sent;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one clock: inputs were set after a falling edge, sample after the rising edge
  task automatic tick();
    @(posedge clk);
    #(PERIOD/4);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; linked = 1'b0;
    sValid = 0; sPe = 0; sData = 0; dValidDir = 0; dPeDir = 0; dDataDir = 0;
    tick(); tick();
    @(negedge clk);
    rst = 1'b0;
    model = '0;
  endtask

  // model step: returns the expected output bit
  function automatic logic model_step(input logic pe, input logic dsMode, input logic d);
    logic o;
    if (!pe) return d;
    o = d ^ model[LEN-1];
    model = {model[LEN-2:0], dsMode ? d : o};
    return o;
  endfunction

  task automatic t_reset();
    do_reset();
    check("R8 outValid after reset", sOutValid, 1'b0);
    check("R8 outData after reset", sOutData, 1'b0);
    check("R8 dsc outValid after reset", dOutValid, 1'b0);
  endtask

  task automatic t_scramble();
    logic e;
    do_reset();
    for (int i = 0; i < 120; i++) begin
      sValid = 1; sPe = 1; sData = 1'($urandom);
      e = model_step(1'b1, 1'b0, sData);
      tick();
      check("R1 R2 R4 scrambled bit", sOutData, e);
      check("R7 valid latency", sOutValid, 1'b1);
      @(negedge clk);
    end
  endtask

  task automatic t_passthru();
    logic e;
    do_reset();
    for (int i = 0; i < 150; i++) begin
      sValid = 1; sPe = ((i % 5) != 0); sData = 1'($urandom);
      e = model_step(sPe, 1'b0, sData);
      tick();
      if (!sPe) check("R5 non-payload passes unchanged", sOutData, sData);
      else      check("R5 history kept across non-payload", sOutData, e);
      @(negedge clk);
    end
  endtask

  task automatic t_gaps();
    logic e, held;
    do_reset();
    for (int i = 0; i < 120; i++) begin
      if ((i % 4) == 3) begin
        held = sOutData;
        sValid = 0; sPe = 1; sData = ~sData;
        tick();
        check("R6 outValid drops", sOutValid, 1'b0);
        check("R6 outData holds", sOutData, held);
      end else begin
        sValid = 1; sPe = 1; sData = 1'($urandom);
        e = model_step(1'b1, 1'b0, sData);
        tick();
        check("R6 history paused over gap", sOutData, e);
        check("R7 valid returns", sOutValid, 1'b1);
      end
      @(negedge clk);
    end
  endtask

  task automatic t_descramble();
    logic e;
    do_reset();
    for (int i = 0; i < 100; i++) begin
      dValidDir = 1; dPeDir = 1; dDataDir = 1'($urandom);
      e = model_step(1'b1, 1'b1, dDataDir);
      tick();
      check("R3 descrambled bit", dOutData, e);
      @(negedge clk);
    end
  endtask

  task automatic t_selfsync();
    do_reset();
    // fill the descrambler history with junk
    for (int i = 0; i < 30; i++) begin
      dValidDir = 1; dPeDir = 1; dDataDir = 1'($urandom);
      tick();
      @(negedge clk);
    end
    linked = 1'b1;
    for (int k = 0; k < 160; k++) begin
      sValid = 1; sPe = 1; sData = 1'($urandom);
      sent[k] = sData;
      tick();
      if (k - 1 >= LEN) check("R9 payload recovered after sync", dOutData, sent[k-1]);
      @(negedge clk);
    end
    sValid = 0;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_scramble();
        t_passthru();
        t_gaps();
        t_descramble();
        t_selfsync();
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule